// File: doc/BRIEF.md
# MSI doorbell interrupt aggregator

This block collects message-signaled interrupts that arrive as writes to a single doorbell address. The data word of each doorbell write carries a vector number from 0 to 255. That vector's pending bit is set, and the pending bit stays set until software clears it. Software reads the pending bits through eight 32-bit status words and clears them by writing ones. A second bank of eight 32-bit words holds a per-vector unmask bit.

Every vector that is both pending and unmasked is merged into one registered, level-sensitive interrupt line toward the host CPU. The handler reads the status words, acknowledges each bit it finds by writing a one to it, and then services the vector. A doorbell that arrives while its vector is masked is still recorded, so the event is not lost. It raises the interrupt once software unmasks the vector.

Top module: `msi_doorbell_agg`

## Requirements
- R1: After a synchronous active-low reset, all status and enable bits read as zero and `irq` is low.
- R2: A doorbell write with `db_valid` high, `db_addr` equal to the `DB_ADDR` parameter and `db_data` below 256 sets vector n = `db_data` on the next clock edge. Vector n is bit n mod 32 of the status word at byte offset 0x80 + 4·(n/32).
- R3: A doorbell write whose address differs from `DB_ADDR`, or whose data is 256 or more, changes no status bit.
- R4: A register write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: The enable words sit at byte offsets 0xA0 + 4·w for w = 0..7 and use the same vector-to-bit mapping as the status words. A write replaces the whole word, and a read returns the last value written.
- R6: `irq` is registered. It goes high one clock edge after any vector is both pending and enabled, and it goes low one edge after no such vector remains.
- R7: A doorbell to a masked vector still sets its status bit without raising `irq`. Enabling the vector later raises `irq`.
- R8: When a doorbell set and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Reads of any offset that is not an aligned status or enable word return zero, and writes to such offsets change no state.
- R10: Writing ones to a status bit that is clear leaves it clear; only a doorbell can set a status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_addr | input | 32 | Doorbell write address |
| db_data | input | 32 | Doorbell write data (vector number) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Merged interrupt to the host |

## Verification
The bench probes the ends of each status word (vectors 0, 31, 32, 63 and 255) and the out-of-range values 256 and above. A design with an off-by-one word split would light the wrong word, and one that dropped the range check would alias vector 256 onto vector 0. It drives a doorbell and a clear onto the same bit in the same cycle, where a design that let the clear win would lose an event. It also rings a masked vector and enables it only afterwards, where a design that gated the set with the enable would never interrupt. Writes of ones into clear status bits and accesses to misaligned or unmapped offsets check that software can neither create interrupts nor corrupt the enables through stray writes.

// File: rtl/msi_agg_pkg.sv
// Package: shared types for the MSI doorbell aggregator.
// Assumes a register port with byte offsets and 32-bit words.
package msi_agg_pkg;

    localparam int unsigned WORD_W = 32;

    // Which register bank a register-port offset selects.
    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_STATUS = 2'd1,
        RGN_ENABLE = 2'd2
    } reg_region_e;

endpackage

// File: rtl/msi_db_decode.sv
// Module: msi_db_decode
// Qualifies a doorbell write. It fires only for the configured address and a
// vector number below NUM_VEC. Assumes one doorbell write per cycle at most.
module msi_db_decode #(
    parameter int unsigned NUM_VEC   = 256,
    parameter int unsigned DB_ADDR_W = 32,
    parameter int unsigned DB_DATA_W = 32,
    parameter logic [DB_ADDR_W-1:0] DB_ADDR = 32'h0000_F040,
    localparam int unsigned IDX_W = $clog2(NUM_VEC)
) (
    input  logic                 db_valid,
    input  logic [DB_ADDR_W-1:0] db_addr,
    input  logic [DB_DATA_W-1:0] db_data,
    output logic                 set_fire,
    output logic [IDX_W-1:0]     set_idx
);

    // Purpose: accept the write only on the exact address with an in-range vector.
    always_comb begin
        set_fire = db_valid && (db_addr == DB_ADDR) && (db_data < DB_DATA_W'(NUM_VEC));
        set_idx  = db_data[IDX_W-1:0];
    end

endmodule

// File: rtl/msi_reg_bank.sv
// Module: msi_reg_bank
// Holds the pending (status) and unmask (enable) bits. Status bits are set by
// the qualified doorbell and cleared by write-one-to-clear, with the set
// taking precedence. Enable words are plain read/write. Assumes NUM_VEC is a
// multiple of 32 and that both banks fit inside the register address space.
module msi_reg_bank
    import msi_agg_pkg::*;
#(
    parameter int unsigned NUM_VEC   = 256,
    parameter int unsigned RADDR_W   = 8,
    parameter int unsigned STAT_BASE = 'h80,
    parameter int unsigned EN_BASE   = 'hA0,
    localparam int unsigned IDX_W     = $clog2(NUM_VEC),
    localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W,
    localparam int unsigned WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned STAT_END  = STAT_BASE + 4 * NUM_WORDS,
    localparam int unsigned EN_END    = EN_BASE + 4 * NUM_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_fire,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               reg_wr,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NUM_VEC-1:0] status_o,
    output logic [NUM_VEC-1:0] enable_o
);

    logic [NUM_VEC-1:0] status_q;
    logic [NUM_VEC-1:0] enable_q;
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] clr_vec;
    logic [31:0]        addr_ext;
    reg_region_e        region;
    logic [WSEL_W-1:0]  word_sel;

    // Purpose: map the byte offset onto a bank and a word index, aligned words only.
    always_comb begin
        addr_ext = 32'(reg_addr);
        region   = RGN_NONE;
        word_sel = '0;
        if (addr_ext[1:0] == 2'b00) begin
            if (addr_ext >= STAT_BASE && addr_ext < STAT_END) begin
                region   = RGN_STATUS;
                word_sel = WSEL_W'((addr_ext - STAT_BASE) >> 2);
            end else if (addr_ext >= EN_BASE && addr_ext < EN_END) begin
                region   = RGN_ENABLE;
                word_sel = WSEL_W'((addr_ext - EN_BASE) >> 2);
            end
        end
    end

    // Purpose: expand the qualified doorbell into a one-hot set vector.
    always_comb begin
        set_vec = '0;
        if (set_fire) begin
            set_vec[set_idx] = 1'b1;
        end
    end

    // Per-word clear masks and enable registers.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign clr_vec[w*WORD_W +: WORD_W] =
            (reg_wr && region == RGN_STATUS && word_sel == WSEL_W'(w)) ? reg_wdata : '0;

        // Purpose: replace an enable word on a register write to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enable_q[w*WORD_W +: WORD_W] <= '0;
            end else if (reg_wr && region == RGN_ENABLE && word_sel == WSEL_W'(w)) begin
                enable_q[w*WORD_W +: WORD_W] <= reg_wdata;
            end
        end
    end

    // Purpose: update pending bits; a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
        end
    end

    // Purpose: return the selected word, zero for unmapped offsets.
    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RGN_STATUS: reg_rdata = status_q[WORD_W*word_sel +: WORD_W];
            RGN_ENABLE: reg_rdata = enable_q[WORD_W*word_sel +: WORD_W];
            default:    reg_rdata = '0;
        endcase
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

    // R1: a reset cycle leaves both banks empty.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && enable_q == '0));

    // R2 and R8: a qualified doorbell always leaves its bit set, even against a clear.
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_fire |=> status_q[$past(set_idx)]);

    // R10: without a doorbell no status bit can rise.
    a_r10_no_set_without_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        !set_fire |=> ((status_q & ~$past(status_q)) == '0));

    // R5 and R9: enables move only on a write to an enable word.
    a_r5_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && region == RGN_ENABLE) |=> $stable(enable_q));

endmodule

// File: rtl/msi_irq_merge.sv
// Module: msi_irq_merge
// Reduces all pending-and-enabled vectors into one registered level interrupt.
// Assumes status and enable come from registers in the same clock domain.
module msi_irq_merge #(
    parameter int unsigned NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] status_i,
    input  logic [NUM_VEC-1:0] enable_i,
    output logic               irq_o
);

    logic irq_q;

    // Purpose: register the OR of every unmasked pending vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_i & enable_i);
        end
    end

    assign irq_o = irq_q;

    // R6: an unmasked pending vector raises the line one edge later.
    a_r6_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & enable_i)) |=> irq_o);

    // R7: with every vector masked, the line is low one edge later.
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |=> !irq_o);

endmodule

// File: rtl/msi_doorbell_agg.sv
// Module: msi_doorbell_agg (top)
// Doorbell-driven MSI aggregator: decode, pending/enable banks, and merged IRQ.
// Assumes a single clock, synchronous active-low reset, and register reads
// that are combinational from the offset.
module msi_doorbell_agg
    import msi_agg_pkg::*;
#(
    parameter int unsigned NUM_VEC   = 256,
    parameter int unsigned DB_ADDR_W = 32,
    parameter int unsigned DB_DATA_W = 32,
    parameter logic [DB_ADDR_W-1:0] DB_ADDR = 32'h0000_F040,
    parameter int unsigned RADDR_W   = 8,
    parameter int unsigned STAT_BASE = 'h80,
    parameter int unsigned EN_BASE   = 'hA0,
    localparam int unsigned IDX_W    = $clog2(NUM_VEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 db_valid,
    input  logic [DB_ADDR_W-1:0] db_addr,
    input  logic [DB_DATA_W-1:0] db_data,
    input  logic                 reg_wr,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 irq
);

    logic               set_fire;
    logic [IDX_W-1:0]   set_idx;
    logic [NUM_VEC-1:0] status_w;
    logic [NUM_VEC-1:0] enable_w;

    msi_db_decode #(
        .NUM_VEC   (NUM_VEC),
        .DB_ADDR_W (DB_ADDR_W),
        .DB_DATA_W (DB_DATA_W),
        .DB_ADDR   (DB_ADDR)
    ) u_decode (
        .db_valid (db_valid),
        .db_addr  (db_addr),
        .db_data  (db_data),
        .set_fire (set_fire),
        .set_idx  (set_idx)
    );

    msi_reg_bank #(
        .NUM_VEC   (NUM_VEC),
        .RADDR_W   (RADDR_W),
        .STAT_BASE (STAT_BASE),
        .EN_BASE   (EN_BASE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_fire  (set_fire),
        .set_idx   (set_idx),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status_o  (status_w),
        .enable_o  (enable_w)
    );

    msi_irq_merge #(
        .NUM_VEC (NUM_VEC)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .enable_i (enable_w),
        .irq_o    (irq)
    );

    // R3: a foreign-address or out-of-range doorbell adds no pending bit.
    a_r3_bad_doorbell_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && (db_addr != DB_ADDR || db_data >= DB_DATA_W'(NUM_VEC)))
        |=> ($countones(status_w) <= $countones($past(status_w))));

endmodule

// File: tb/msi_doorbell_agg_tb.sv
`timescale 1ns/1ps
module msi_doorbell_agg_tb;

    localparam logic [31:0] DB = 32'h0000_F040;
    localparam int NTV = 10;
    // Doorbell table: data value and whether the address is the correct one.
    localparam logic [31:0] TV_DATA [NTV] = '{32'd0, 32'd31, 32'd32, 32'd63, 32'd100,
                                             32'd255, 32'd256, 32'd300, 32'd5, 32'hFFFF_FF00};
    localparam bit TV_GOOD [NTV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                     1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        db_valid = 1'b0;
    logic [31:0] db_addr = '0;
    logic [31:0] db_data = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    msi_doorbell_agg #(.DB_ADDR(DB)) u_dut (
        .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_addr(db_addr),
        .db_data(db_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic ring(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        db_valid = 1'b1; db_addr = a; db_data = d;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic clear_all();
        for (int w = 0; w < 8; w++) begin
            wr(8'h80 + 8'(4*w), 32'hFFFF_FFFF);
            wr(8'hA0 + 8'(4*w), 32'h0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 8; w++) begin
            rd(8'h80 + 8'(4*w), d); chk("R1 status reset", d, 32'h0);
            rd(8'hA0 + 8'(4*w), d); chk("R1 enable reset", d, 32'h0);
        end
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // R2/R3: table of doorbells, expected word and bit computed here
        for (int t = 0; t < NTV; t++) begin
            clear_all();
            ring(TV_GOOD[t] ? DB : (DB ^ 32'h4), TV_DATA[t]);
            for (int w = 0; w < 8; w++) begin
                exp = 32'h0;
                if (TV_GOOD[t] && TV_DATA[t] < 256 && int'(TV_DATA[t] / 32) == w)
                    exp = 32'h1 << (TV_DATA[t] % 32);
                rd(8'h80 + 8'(4*w), d);
                chk((TV_GOOD[t] && TV_DATA[t] < 256) ? "R2 doorbell sets" : "R3 doorbell ignored",
                    d, exp);
            end
        end

        // R5: enable readback per word
        clear_all();
        wr(8'hAC, 32'hA5A5_5A5A);
        wr(8'hBC, 32'h8000_0001);
        rd(8'hAC, d); chk("R5 enable word3", d, 32'hA5A5_5A5A);
        rd(8'hBC, d); chk("R5 enable word7", d, 32'h8000_0001);
        rd(8'hA0, d); chk("R5 enable word0 untouched", d, 32'h0);
        chk("R7 irq quiet without pending", {31'b0, irq}, 32'h0);

        // R6: vector 70 = word 2 bit 6, enabled, then rung
        clear_all();
        wr(8'hA8, 32'h0000_0040);
        ring(DB, 32'd70);
        chk("R6 irq not yet (registered)", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R6 irq raised", {31'b0, irq}, 32'h1);

        // R4: a zero write keeps the bit, a one write clears it
        wr(8'h88, 32'h0);
        rd(8'h88, d); chk("R4 zero write keeps", d, 32'h0000_0040);
        wr(8'h88, 32'h0000_0040);
        rd(8'h88, d); chk("R4 one write clears", d, 32'h0);
        @(negedge clk);
        chk("R6 irq falls after clear", {31'b0, irq}, 32'h0);

        // R7: vector 200 = word 6 bit 8, masked then unmasked
        ring(DB, 32'd200);
        @(negedge clk);
        rd(8'h98, d); chk("R7 masked still pending", d, 32'h0000_0100);
        chk("R7 masked no irq", {31'b0, irq}, 32'h0);
        wr(8'hB8, 32'h0000_0100);
        @(negedge clk);
        chk("R7 irq after unmask", {31'b0, irq}, 32'h1);

        // R8: same-cycle set and clear on vector 10; bit 3 cleared normally
        clear_all();
        ring(DB, 32'd10);
        ring(DB, 32'd3);
        @(negedge clk);
        db_valid = 1'b1; db_addr = DB; db_data = 32'd10;
        reg_wr = 1'b1; reg_addr = 8'h80; reg_wdata = 32'h0000_0408;
        @(negedge clk);
        db_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(8'h80, d); chk("R8 set wins over clear", d, 32'h0000_0400);

        // R10: writing ones to clear status bits does not set them
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, d); chk("R10 no set by write", d, 32'h0);

        // R9: unmapped and misaligned offsets
        wr(8'hA4, 32'h1234_5678);
        rd(8'h00, d); chk("R9 unmapped read 0x00", d, 32'h0);
        rd(8'h7C, d); chk("R9 unmapped read 0x7C", d, 32'h0);
        rd(8'hC0, d); chk("R9 unmapped read 0xC0", d, 32'h0);
        rd(8'h81, d); chk("R9 misaligned read 0x81", d, 32'h0);
        wr(8'hC0, 32'hFFFF_FFFF);
        wr(8'hA5, 32'hFFFF_FFFF);
        rd(8'hA4, d); chk("R9 enable unchanged by stray writes", d, 32'h1234_5678);
        rd(8'h80, d); chk("R9 status unchanged by stray writes", d, 32'h0000_0400);

        // R1: reset in the middle of activity
        wr(8'hA0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R1 irq before reset", {31'b0, irq}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h80, d); chk("R1 status after reset", d, 32'h0);
        rd(8'hA0, d); chk("R1 enable after reset", d, 32'h0);
        rd(8'hA4, d); chk("R1 enable word1 after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule